// File: doc/BRIEF.md
# Gate privilege transfer checker

This block decides the outcome of a control transfer that passes through a gate descriptor in a segmented protected-mode CPU. The microcode or sequencer presents the current privilege level, the gate selector (or an interrupt vector), the kind of transfer, and the already fetched fields of the gate and of the target code descriptor. One cycle later the block reports one of three outcomes: a general-protection fault with the selector to report, a transfer at the same privilege, or a transfer to a more privileged level.

The gate stage checks whether the gate may be used at all. Its rules depend on the transfer kind. The code stage then compares the privilege of the target code segment with the current level, and uses the conforming bit to split the transfer into a same-privilege case, a more-privilege case, or a fault. A more-privilege result asks for a stack switch and gives the new CPL. Descriptor fetch, table limit checks and the task-state lookup are handled elsewhere.

Top module: `gate_xfer_chk`

## Requirements
- R1: `valid_o` is high in the cycle after a cycle in which `req_i` is high, and low after a cycle in which `req_i` is low. The outputs are registered when the request is accepted.
- R2: A gate whose present bit is clear faults with the gate selector. This check comes before every other check.
- R3: For a call (kind 0) or a jump (kind 3), the gate fails unless the gate DPL is numerically greater than or equal to both CPL and the selector RPL (`gate_sel_i[1:0]`). Such a failure faults with the gate selector.
- R4: For a software interrupt (kind 1), the gate DPL must be greater than or equal to CPL, otherwise the block faults with the gate selector. For an exception or external interrupt (kind 2), the gate DPL is not checked.
- R5: For kinds 1 and 2, the gate selector is `{vector_i, 3'b000}`, zero-extended to the selector width. The table-indicator bit and the RPL are both zero.
- R6: A target descriptor that is not executable or not present faults with the code selector. The reported code selector always has its RPL bits [1:0] forced to zero, because the RPL held in the gate is ignored.
- R7: A target code DPL numerically greater than CPL faults with the code selector.
- R8: A transfer is same-privilege when the target DPL equals CPL, or when the target DPL is below CPL and the segment is conforming. In that case `same_pl_o`=1, `new_cpl_o` equals CPL and `stack_switch_o`=0.
- R9: A call or an exception/interrupt to a non-conforming target with DPL below CPL is a more-privilege transfer: `more_pl_o`=1, `stack_switch_o`=1 and `new_cpl_o` equals the target DPL.
- R10: A software interrupt or a jump that would need a more-privilege transfer faults with the code selector instead.
- R11: With `valid_o` high, exactly one of `fault_o`, `same_pl_o` and `more_pl_o` is set. On a fault, `stack_switch_o`=0 and `new_cpl_o` equals CPL. With no fault, `fault_sel_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| kind_i | input | 2 | 0 call, 1 software interrupt, 2 exception/external interrupt, 3 jump |
| cpl_i | input | 2 | Current privilege level |
| gate_sel_i | input | 16 | Gate selector for call/jump |
| vector_i | input | 8 | Interrupt vector for kinds 1 and 2 |
| gate_present_i | input | 1 | Gate present bit |
| gate_dpl_i | input | 2 | Gate DPL |
| code_sel_i | input | 16 | Code selector held in the gate |
| code_present_i | input | 1 | Target present bit |
| code_dpl_i | input | 2 | Target DPL |
| code_exec_i | input | 1 | Target executable bit |
| code_conf_i | input | 1 | Target conforming bit |
| valid_o | output | 1 | Result strobe, one cycle after request |
| fault_o | output | 1 | General-protection fault |
| fault_sel_o | output | 16 | Selector to report with the fault |
| same_pl_o | output | 1 | Same-privilege transfer |
| more_pl_o | output | 1 | More-privilege transfer |
| new_cpl_o | output | 2 | CPL after the transfer |
| stack_switch_o | output | 1 | Stack switch request |

## Verification
The block holds no state across requests, so a fault in the gate or code stage shows at the ports in the cycle that follows the offending request. It appears as a wrong outcome flag, a wrong selector (gate instead of code, or an RPL that was not stripped), or a CPL that is wrong or that moves on a fault. A broken handshake register shows as a missing valid pulse, or one that lasts more than one cycle. Each scenario checks both the result cycle and the cycle after it.

// File: rtl/gate_pkg.sv
package gate_pkg;
  typedef enum logic [1:0] {
    KIND_CALL  = 2'd0,
    KIND_SWINT = 2'd1,
    KIND_EXTINT = 2'd2,
    KIND_JUMP  = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/gate_lvl_chk.sv
module gate_lvl_chk
  import gate_pkg::*;
#(
  parameter int PL_W  = 2,
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input  xfer_kind_e       kind_i,
  input  logic [PL_W-1:0]  cpl_i,
  input  logic [SEL_W-1:0] gate_sel_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic             gate_present_i,
  input  logic [PL_W-1:0]  gate_dpl_i,
  output logic             gate_np_o,
  output logic             gate_dpl_bad_o,
  output logic [SEL_W-1:0] gate_sel_o
);
  localparam int PAD = SEL_W - VEC_W - 3;

  logic [SEL_W-1:0] vec_sel;
  logic [PL_W-1:0]  rpl;
  logic             is_int;

  generate
    if (PAD > 0) begin : g_pad
      assign vec_sel = {{PAD{1'b0}}, vector_i, 3'b000};
    end else begin : g_trunc
      logic [VEC_W+2:0] full_sel;
      assign full_sel = {vector_i, 3'b000};
      assign vec_sel  = full_sel[SEL_W-1:0];
    end
  endgenerate

  assign rpl    = gate_sel_i[PL_W-1:0];
  assign is_int = (kind_i == KIND_SWINT) || (kind_i == KIND_EXTINT);
  assign gate_sel_o = is_int ? vec_sel : gate_sel_i;
  assign gate_np_o  = !gate_present_i;

  always_comb begin
    unique case (kind_i)
      KIND_CALL, KIND_JUMP: gate_dpl_bad_o = (gate_dpl_i < cpl_i) || (gate_dpl_i < rpl);
      KIND_SWINT:           gate_dpl_bad_o = (gate_dpl_i < cpl_i);
      default:              gate_dpl_bad_o = 1'b0; // exceptions skip the gate DPL
    endcase
  end
endmodule

// File: rtl/code_lvl_chk.sv
module code_lvl_chk
  import gate_pkg::*;
#(
  parameter int PL_W = 2
) (
  input  xfer_kind_e      kind_i,
  input  logic [PL_W-1:0] cpl_i,
  input  logic            code_present_i,
  input  logic [PL_W-1:0] code_dpl_i,
  input  logic            code_exec_i,
  input  logic            code_conf_i,
  output logic            code_fault_o,
  output logic            same_o,
  output logic            more_o
);
  logic may_raise;
  assign may_raise = (kind_i == KIND_CALL) || (kind_i == KIND_EXTINT);

  always_comb begin
    code_fault_o = 1'b0;
    same_o       = 1'b0;
    more_o       = 1'b0;
    if (!code_exec_i || !code_present_i)          code_fault_o = 1'b1;
    else if (code_dpl_i > cpl_i)                  code_fault_o = 1'b1;
    else if (code_dpl_i == cpl_i || code_conf_i)  same_o       = 1'b1;
    else if (may_raise)                           more_o       = 1'b1;
    else                                          code_fault_o = 1'b1;
  end
endmodule

// File: rtl/gate_xfer_chk.sv
module gate_xfer_chk
  import gate_pkg::*;
#(
  parameter int PL_W  = 2,
  parameter int SEL_W = 16,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [1:0]       kind_i,
  input  logic [PL_W-1:0]  cpl_i,
  input  logic [SEL_W-1:0] gate_sel_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic             gate_present_i,
  input  logic [PL_W-1:0]  gate_dpl_i,
  input  logic [SEL_W-1:0] code_sel_i,
  input  logic             code_present_i,
  input  logic [PL_W-1:0]  code_dpl_i,
  input  logic             code_exec_i,
  input  logic             code_conf_i,
  output logic             valid_o,
  output logic             fault_o,
  output logic [SEL_W-1:0] fault_sel_o,
  output logic             same_pl_o,
  output logic             more_pl_o,
  output logic [PL_W-1:0]  new_cpl_o,
  output logic             stack_switch_o
);
  xfer_kind_e       kind;
  logic             gate_np, gate_dpl_bad, code_fault, same_c, more_c;
  logic             gate_fault, fault_c;
  logic [SEL_W-1:0] gate_sel_eff, code_sel_clean, sel_c;

  assign kind = xfer_kind_e'(kind_i);

  gate_lvl_chk #(.PL_W(PL_W), .SEL_W(SEL_W), .VEC_W(VEC_W)) i_gate (
    .kind_i         (kind),
    .cpl_i          (cpl_i),
    .gate_sel_i     (gate_sel_i),
    .vector_i       (vector_i),
    .gate_present_i (gate_present_i),
    .gate_dpl_i     (gate_dpl_i),
    .gate_np_o      (gate_np),
    .gate_dpl_bad_o (gate_dpl_bad),
    .gate_sel_o     (gate_sel_eff)
  );

  code_lvl_chk #(.PL_W(PL_W)) i_code (
    .kind_i         (kind),
    .cpl_i          (cpl_i),
    .code_present_i (code_present_i),
    .code_dpl_i     (code_dpl_i),
    .code_exec_i    (code_exec_i),
    .code_conf_i    (code_conf_i),
    .code_fault_o   (code_fault),
    .same_o         (same_c),
    .more_o         (more_c)
  );

  // gate RPL is ignored: report the code selector with RPL cleared
  assign code_sel_clean = {code_sel_i[SEL_W-1:PL_W], {PL_W{1'b0}}};
  assign gate_fault     = gate_np || gate_dpl_bad;
  assign fault_c        = gate_fault || code_fault;
  assign sel_c          = gate_fault ? gate_sel_eff : code_sel_clean;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      fault_o        <= 1'b0;
      fault_sel_o    <= '0;
      same_pl_o      <= 1'b0;
      more_pl_o      <= 1'b0;
      new_cpl_o      <= '0;
      stack_switch_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        fault_o        <= fault_c;
        fault_sel_o    <= fault_c ? sel_c : '0;
        same_pl_o      <= !fault_c && same_c;
        more_pl_o      <= !fault_c && more_c;
        new_cpl_o      <= (!fault_c && more_c) ? code_dpl_i : cpl_i;
        stack_switch_o <= !fault_c && more_c;
      end
    end
  end

  p_valid_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  p_no_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  p_gate_np_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !gate_present_i |=> fault_o && fault_sel_o == $past(gate_sel_eff));
  p_extint_no_dpl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && kind == KIND_EXTINT |-> !gate_dpl_bad);
  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $onehot({fault_o, same_pl_o, more_pl_o}));
  p_fault_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && fault_o |-> !stack_switch_o && new_cpl_o == $past(cpl_i));
  p_same_cpl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && same_pl_o |-> !stack_switch_o && new_cpl_o == $past(cpl_i));
  p_more_cpl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && more_pl_o |-> stack_switch_o && new_cpl_o < $past(cpl_i));
  p_more_kind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && more_pl_o |->
      ($past(kind_i) == KIND_CALL || $past(kind_i) == KIND_EXTINT));
endmodule

// File: tb/test_gate_xfer_chk.sv
module test_gate_xfer_chk;
  import gate_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [1:0]  cpl_i = '0;
  logic [15:0] gate_sel_i = '0;
  logic [7:0]  vector_i = '0;
  logic        gate_present_i = 1'b0;
  logic [1:0]  gate_dpl_i = '0;
  logic [15:0] code_sel_i = '0;
  logic        code_present_i = 1'b0;
  logic [1:0]  code_dpl_i = '0;
  logic        code_exec_i = 1'b0;
  logic        code_conf_i = 1'b0;
  logic        valid_o, fault_o, same_pl_o, more_pl_o, stack_switch_o;
  logic [15:0] fault_sel_o;
  logic [1:0]  new_cpl_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i; // 250 MHz

  gate_xfer_chk i_gate_xfer_chk (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one request, check result cycle and the idle cycle after it
  task automatic run(input string tag, input logic [1:0] k, input logic [1:0] cpl,
                     input logic [15:0] gsel, input logic [7:0] vec, input logic gp,
                     input logic [1:0] gdpl, input logic [15:0] csel, input logic cp,
                     input logic [1:0] cdpl, input logic cx, input logic cc,
                     input logic ef, input logic [15:0] esel, input logic es,
                     input logic em, input logic [1:0] ecpl);
    @(negedge clk_i);
    req_i = 1'b1; kind_i = k; cpl_i = cpl; gate_sel_i = gsel; vector_i = vec;
    gate_present_i = gp; gate_dpl_i = gdpl; code_sel_i = csel;
    code_present_i = cp; code_dpl_i = cdpl; code_exec_i = cx; code_conf_i = cc;
    @(negedge clk_i);
    req_i = 1'b0;
    chk({tag, " R1 valid"}, valid_o, 1'b1);
    chk({tag, " fault"}, fault_o, ef);
    chk({tag, " fault_sel"}, fault_sel_o, esel);
    chk({tag, " same"}, same_pl_o, es);
    chk({tag, " more"}, more_pl_o, em);
    chk({tag, " new_cpl"}, new_cpl_o, ecpl);
    chk({tag, " stack_switch"}, stack_switch_o, em);
    @(negedge clk_i);
    chk({tag, " R1 pulse ends"}, valid_o, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", valid_o, 1'b0);
    chk("R11 reset fault", fault_o, 1'b0);
    chk("R11 reset switch", stack_switch_o, 1'b0);
  endtask

  task automatic t_gate_np;    // R2: np gate wins over bad gate DPL and bad code
    run("R2 gate np", KIND_CALL, 2'd3, 16'h0043, 8'h00, 1'b0, 2'd0, 16'h0008,
        1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 16'h0043, 1'b0, 1'b0, 2'd3);
  endtask

  task automatic t_gate_priv;  // R3
    run("R3 rpl too low", KIND_CALL, 2'd1, 16'h0053, 8'h00, 1'b1, 2'd2, 16'h0008,
        1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0053, 1'b0, 1'b0, 2'd1);
    run("R3 cpl too low", KIND_CALL, 2'd3, 16'h0060, 8'h00, 1'b1, 2'd2, 16'h0008,
        1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0060, 1'b0, 1'b0, 2'd3);
    run("R3 jump gate", KIND_JUMP, 2'd2, 16'h0072, 8'h00, 1'b1, 2'd1, 16'h0008,
        1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 16'h0072, 1'b0, 1'b0, 2'd2);
  endtask

  task automatic t_swint;      // R4 R5
    run("R4 R5 swint dpl", KIND_SWINT, 2'd3, 16'hFFFF, 8'h0D, 1'b1, 2'd0, 16'h0008,
        1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 16'h0068, 1'b0, 1'b0, 2'd3);
    run("R5 high vector", KIND_SWINT, 2'd0, 16'h0000, 8'hFF, 1'b0, 2'd0, 16'h0008,
        1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 16'h07F8, 1'b0, 1'b0, 2'd0);
    run("R4 swint same", KIND_SWINT, 2'd0, 16'h0000, 8'h30, 1'b1, 2'd0, 16'h0008,
        1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd0);
  endtask

  task automatic t_extint;     // R4 R9 R7
    run("R4 R9 extint raise", KIND_EXTINT, 2'd3, 16'h0000, 8'h20, 1'b1, 2'd0, 16'h0010,
        1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd0);
    run("R7 extint lower", KIND_EXTINT, 2'd1, 16'h0000, 8'h21, 1'b1, 2'd0, 16'h002A,
        1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 16'h0028, 1'b0, 1'b0, 2'd1);
  endtask

  task automatic t_code_bad;   // R6
    run("R6 code np", KIND_CALL, 2'd3, 16'h0043, 8'h00, 1'b1, 2'd3, 16'h001B,
        1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0018, 1'b0, 1'b0, 2'd3);
    run("R6 code nx", KIND_CALL, 2'd2, 16'h0042, 8'h00, 1'b1, 2'd3, 16'h0021,
        1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 16'h0020, 1'b0, 1'b0, 2'd2);
  endtask

  task automatic t_call;       // R8 R9
    run("R9 call raise", KIND_CALL, 2'd3, 16'h0043, 8'h00, 1'b1, 2'd3, 16'h000B,
        1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd1);
    run("R8 call equal", KIND_CALL, 2'd2, 16'h0042, 8'h00, 1'b1, 2'd3, 16'h0008,
        1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd2);
    run("R8 conforming", KIND_CALL, 2'd3, 16'h0043, 8'h00, 1'b1, 2'd3, 16'h0008,
        1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd3);
  endtask

  task automatic t_no_raise;   // R10
    run("R10 swint raise", KIND_SWINT, 2'd3, 16'h0000, 8'h03, 1'b1, 2'd3, 16'h0012,
        1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 16'h0010, 1'b0, 1'b0, 2'd3);
    run("R10 jump raise", KIND_JUMP, 2'd3, 16'h0043, 8'h00, 1'b1, 2'd3, 16'h0009,
        1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 16'h0008, 1'b0, 1'b0, 2'd3);
    run("R10 jump conf", KIND_JUMP, 2'd3, 16'h0043, 8'h00, 1'b1, 2'd3, 16'h0009,
        1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd3);
  endtask

  task automatic t_idle;       // R1
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R1 idle", valid_o, 1'b0);
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_gate_np();
    t_gate_priv();
    t_swint();
    t_extint();
    t_code_bad();
    t_call();
    t_no_raise();
    t_idle();
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end
endmodule